// File: doc/BRIEF.md
# Grouped Lookahead Adder/Subtractor

This block adds or subtracts two WIDTH-bit binary operands with no internal state: the outputs follow the inputs combinationally. The operands are cut into 4-bit slices. Inside a slice, four full-adder stages pass their carries from one to the next. The carry that leaves a slice does not come from that chain. Each slice forms a slice-wide generate and propagate term and computes its outgoing carry from them, so the carry into the next slice settles after a short two-level expression rather than after four stages.

Subtraction uses two's complement. When `sub_mode` is high, the second operand is bit-inverted and the carry into the lowest slice is forced to 1, which yields `op_a - op_b`. The block reports two flags. `carry_out` is the carry out of the top bit and serves as the unsigned range flag. `ovf` is the signed overflow flag: it is set when the carry into the top bit differs from the carry out of it. WIDTH must be a multiple of 4.

Top module: `lookahead_addsub`

## Requirements
- R1: With `sub_mode`=0, `{carry_out, result}` equals `op_a + op_b + carry_in`, taken as a WIDTH+1-bit unsigned sum.
- R2: With `sub_mode`=1, `result` equals `op_a - op_b` modulo 2^WIDTH. `carry_out` equals bit WIDTH of `op_a + ~op_b + 1`, so it is 1 exactly when `op_a >= op_b` as unsigned numbers.
- R3: With `sub_mode`=1, `carry_in` has no effect on `result`, `carry_out` or `ovf`.
- R4: `ovf` is 1 exactly when the signed result falls outside the WIDTH-bit two's-complement range. For addition this is `op_a + op_b + carry_in`; for subtraction it is `op_a - op_b`. At WIDTH=8: 0x7F+0x01 sets it, 0x81+0xFE sets it, 0xF1+0xF1 clears it, and 0x80-0x01 sets it.
- R5: Carries cross every 4-bit slice boundary correctly. An all-ones `op_a` plus zero with `carry_in`=1 gives `result`=0 and `carry_out`=1, and 0x0F+0x01 gives 0x10.
- R6: In every slice, the carry computed from the slice generate and propagate terms equals the carry out of that slice's fourth ripple stage.
- R7: With all inputs at zero, `result` is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Carry into bit 0 during addition |
| sub_mode | input | 1 | 1 selects subtraction, 0 selects addition |
| result | output | WIDTH | Sum or difference modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit (unsigned range flag) |
| ovf | output | 1 | Signed two's-complement overflow |

## Verification
The block holds no state, so any wrong internal carry appears at the ports as soon as the inputs settle. A wrong slice carry corrupts `result` from bit 4k of the next slice upward, and when it reaches the top slice it also corrupts `carry_out` and `ovf`. A wrong carry inside a slice first shows at the bit directly above the faulty stage. The bench drives every 8-bit operand pair in both modes with both values of `carry_in`, so every slice-boundary carry pattern is observed. Long 32-bit carry chains, from random and directed operands, show whether a carry travels correctly across all eight slices.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;
  localparam int unsigned SLICE_BITS = 4;

  function automatic logic bit_gen(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bit_prop(input logic x, input logic y);
    return x ^ y;
  endfunction

  // Slice-wide generate: nested two-level form over four stages.
  function automatic logic slice_gen(input logic [3:0] g, input logic [3:0] p);
    return g[3] | (p[3] & (g[2] | (p[2] & (g[1] | (p[1] & g[0])))));
  endfunction

  function automatic logic slice_prop(input logic [3:0] p);
    return &p;
  endfunction
endpackage

// File: rtl/la_operand_prep.sv
module la_operand_prep #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_raw,
  input  logic             sub_sel,
  input  logic             cin_raw,
  output logic [WIDTH-1:0] b_eff,
  output logic             c_first
);
  // Subtract: invert b and force the bottom carry to 1 (cin ignored).
  assign b_eff   = b_raw ^ {WIDTH{sub_sel}};
  assign c_first = sub_sel | cin_raw;
endmodule

// File: rtl/la_slice4.sv
module la_slice4
  import lookahead_pkg::*;
(
  input  logic [3:0] a_in,
  input  logic [3:0] b_in,
  input  logic       c_in,
  output logic [3:0] s_out,
  output logic       c_top_in,
  output logic       c_out
);
  logic [3:0] g_bit;
  logic [3:0] p_bit;
  logic [4:0] ripple_c;
  logic       sl_gen;
  logic       sl_prop;
  logic       ripple_top;

  assign ripple_c[0] = c_in;

  for (genvar k = 0; k < 4; k++) begin : g_stage
    assign g_bit[k]      = bit_gen(a_in[k], b_in[k]);
    assign p_bit[k]      = bit_prop(a_in[k], b_in[k]);
    assign s_out[k]      = p_bit[k] ^ ripple_c[k];
    assign ripple_c[k+1] = g_bit[k] | (p_bit[k] & ripple_c[k]);
  end

  assign sl_gen     = slice_gen(g_bit, p_bit);
  assign sl_prop    = slice_prop(p_bit);
  assign c_out      = sl_gen | (sl_prop & c_in);
  assign c_top_in   = ripple_c[3];
  assign ripple_top = ripple_c[4];

  always_comb begin
    p_slice_carry_agree_r6: assert (ripple_top == c_out)
      else $error("slice lookahead carry %0b vs ripple %0b", c_out, ripple_top);
    p_slice_sum_r1: assert ({ripple_top, s_out} == ({1'b0, a_in} + {1'b0, b_in} + {4'b0, c_in}))
      else $error("slice sum mismatch");
  end
endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub
  import lookahead_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);
  localparam int unsigned NSLICE = WIDTH / SLICE_BITS;

  logic [WIDTH-1:0]  b_eff;
  logic              c_first;
  logic [NSLICE:0]   slice_c;
  logic [NSLICE-1:0] top_bit_c;

  la_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_raw   (op_b),
    .sub_sel (sub_mode),
    .cin_raw (carry_in),
    .b_eff   (b_eff),
    .c_first (c_first)
  );

  assign slice_c[0] = c_first;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    la_slice4 u_slice (
      .a_in     (op_a[s*SLICE_BITS +: SLICE_BITS]),
      .b_in     (b_eff[s*SLICE_BITS +: SLICE_BITS]),
      .c_in     (slice_c[s]),
      .s_out    (result[s*SLICE_BITS +: SLICE_BITS]),
      .c_top_in (top_bit_c[s]),
      .c_out    (slice_c[s+1])
    );
  end

  assign carry_out = slice_c[NSLICE];
  assign ovf       = top_bit_c[NSLICE-1] ^ slice_c[NSLICE];

  // Behavioural carry into bit position pos of a + b + c.
  function automatic logic carry_into(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                                      input logic c, input int unsigned pos);
    logic [WIDTH:0] msk;
    logic [WIDTH:0] tot;
    msk = ({{WIDTH{1'b0}}, 1'b1} << pos) - 1'b1;
    tot = ({1'b0, x} & msk) + ({1'b0, y} & msk) + {{WIDTH{1'b0}}, c};
    return tot[pos];
  endfunction

  always_comb begin
    p_total_sum_r1: assert ({carry_out, result} ==
                            ({1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_first}))
      else $error("total sum mismatch");
    p_ovf_sign_r4: assert (ovf == ((op_a[WIDTH-1] == b_eff[WIDTH-1]) &&
                                   (result[WIDTH-1] != op_a[WIDTH-1])))
      else $error("overflow flag disagrees with sign rule");
    if (sub_mode) begin
      p_sub_diff_r2: assert (result == op_a - op_b)
        else $error("difference mismatch");
    end
    for (int s = 0; s < NSLICE; s++) begin
      p_top_bit_carry_r4: assert (top_bit_c[s] ==
                                  carry_into(op_a, b_eff, c_first, s*SLICE_BITS + 3))
        else $error("carry into bit %0d wrong", s*SLICE_BITS + 3);
    end
  end
endmodule

// File: tb/test_lookahead_addsub.sv
module test_lookahead_addsub;
  localparam int W8  = 8;
  localparam int W32 = 32;
  localparam int WATCHDOG = 150000;
  localparam int NVEC = 13;

  // fields: a, b, carry_in, sub_mode, exp result, exp carry, exp ovf
  localparam logic [27:0] VECS [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R7 all zero
    {8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1},  // R4 127+1
    {8'h81, 8'hFE, 1'b0, 1'b0, 8'h7F, 1'b1, 1'b1},  // R4 -127 + -2
    {8'hF1, 8'hF1, 1'b0, 1'b0, 8'hE2, 1'b1, 1'b0},  // R4 -15 + -15
    {8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // R5 full chain
    {8'h0F, 8'h01, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0},  // R5 slice boundary
    {8'h09, 8'h07, 1'b0, 1'b1, 8'h02, 1'b1, 1'b0},  // R2 9-7
    {8'h04, 8'h07, 1'b0, 1'b1, 8'hFD, 1'b0, 1'b0},  // R2 4-7
    {8'h05, 8'h05, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0},  // R3 cin 0
    {8'h05, 8'h05, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0},  // R3 cin 1
    {8'h80, 8'h01, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b1},  // R4 -128-1
    {8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 1'b0, 1'b0},  // R1 with cin
    {8'hFF, 8'hFF, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0}   // R1 max
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W8-1:0]  a8, b8, s8;
  logic           cin8, sub8, c8, v8;
  logic [W32-1:0] a32, b32, s32;
  logic           cin32, sub32, c32, v32;

  int applied = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  lookahead_addsub #(.WIDTH(W8)) i_lookahead_addsub_n8 (
    .op_a(a8), .op_b(b8), .carry_in(cin8), .sub_mode(sub8),
    .result(s8), .carry_out(c8), .ovf(v8)
  );

  lookahead_addsub #(.WIDTH(W32)) i_lookahead_addsub (
    .op_a(a32), .op_b(b32), .carry_in(cin32), .sub_mode(sub32),
    .result(s32), .carry_out(c32), .ovf(v32)
  );

  // Independent reference: integer arithmetic with explicit range tests.
  task automatic reference(input int w, input longint a, input longint b, input bit cin,
                           input bit sub, output longint es, output bit ec, output bit ev);
    longint full, msk, tot, sa, sb, tr, half;
    full = longint'(1) << w;
    msk  = full - 1;
    half = full >> 1;
    tot  = sub ? (a + ((~b) & msk) + 1) : (a + b + longint'(cin));
    es   = tot & msk;
    ec   = ((tot >> w) & 1) != 0;
    sa   = (a >= half) ? a - full : a;
    sb   = (b >= half) ? b - full : b;
    tr   = sub ? (sa - sb) : (sa + sb + longint'(cin));
    ev   = (tr > half - 1) || (tr < -half);
  endtask

  task automatic compare(input string tag, input longint gs, input bit gc, input bit gv,
                         input longint es, input bit ec, input bit ev);
    applied++;
    if (gs != es) begin
      miscompares++;
      $display("FAIL %s result: got %0h expected %0h", tag, gs, es);
    end
    if (gc != ec) begin
      miscompares++;
      $display("FAIL %s carry_out: got %0b expected %0b", tag, gc, ec);
    end
    if (gv != ev) begin
      miscompares++;
      $display("FAIL R4 ovf (%s): got %0b expected %0b", tag, gv, ev);
    end
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b, input bit cin, input bit sub,
                      input string tag);
    longint es; bit ec, ev;
    a8 = a; b8 = b; cin8 = cin; sub8 = sub;
    #1;
    reference(W8, longint'(a), longint'(b), cin, sub, es, ec, ev);
    compare(tag, longint'(s8), c8, v8, es, ec, ev);
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input bit cin, input bit sub,
                       input string tag);
    longint es; bit ec, ev;
    a32 = a; b32 = b; cin32 = cin; sub32 = sub;
    #1;
    reference(W32, longint'(a), longint'(b), cin, sub, es, ec, ev);
    compare(tag, longint'(s32), c32, v32, es, ec, ev);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; cin8 = 1'b0; sub8 = 1'b0;
    a32 = '0; b32 = '0; cin32 = 1'b0; sub32 = 1'b0;
    #5;
    // R7 idle state on both widths
    compare("R7", longint'(s8), c8, v8, 0, 1'b0, 1'b0);
    compare("R7", longint'(s32), c32, v32, 0, 1'b0, 1'b0);

    // Table walk against hand-computed expectations
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VECS[i];
      a8 = v[27:20]; b8 = v[19:12]; cin8 = v[11]; sub8 = v[10];
      #1;
      compare(v[10] ? "R2" : "R1", longint'(s8), c8, v8,
              longint'(v[9:2]), v[1], v[0]);
    end

    // Exhaustive 8-bit sweep, both modes, both carry-in values (R3 when sub)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        run8(8'(a), 8'(b), 1'b0, 1'b0, "R1");
        run8(8'(a), 8'(b), 1'b1, 1'b0, "R1");
        run8(8'(a), 8'(b), 1'b0, 1'b1, "R2");
        run8(8'(a), 8'(b), 1'b1, 1'b1, "R3");
      end
    end

    // Directed 32-bit corner cases
    run32(32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R5");
    run32(32'h0000_FFFF, 32'h1, 1'b0, 1'b0, "R5");
    run32(32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, "R4");
    run32(32'h8000_0000, 32'h1, 1'b0, 1'b1, "R4");
    run32(32'h0, 32'h8000_0000, 1'b0, 1'b1, "R4");
    run32(32'h1234_5678, 32'h1234_5678, 1'b1, 1'b1, "R3");
    run32(32'h0, 32'h0, 1'b0, 1'b0, "R7");

    // Random 32-bit vectors in both modes
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra, rb;
      bit rc, rs;
      ra = $urandom; rb = $urandom; rc = 1'($urandom); rs = 1'($urandom);
      run32(ra, rb, rc, rs, rs ? "R2" : "R1");
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule